// File: doc/BRIEF.md
# SEC-DED ECC codec with write-path error injection

This block guards 64-bit memory words with an 8-bit check byte. On the way into memory it computes the check byte from the data word through a fixed parity matrix. A small register port can load XOR masks that corrupt the outgoing data word and check byte on purpose, so that software can provoke known faults and exercise the read-side handling. The masks are applied after the check byte has been computed, so a later read of that word sees a genuine mismatch.

On the way out of memory the block recomputes the check byte of the returned word and XORs it with the stored byte to form a syndrome. A syndrome equal to the matrix column of one data bit marks that bit as flipped, and the bit is inverted. A single-bit syndrome that matches no data column marks a flipped check bit, and the check byte is repaired. Any other nonzero syndrome is reported as uncorrectable. The decode is combinational and feeds one register stage. The write path has no register stage.

Top module: `ecc_secded_codec`

## Requirements
- R1: Bit i of `wr_chk_o` is the XOR reduction of `wr_data_i` ANDed with 64-bit mask M(i), when injection is disabled. Each mask is written {data[63:32] half, data[31:0] half}: M(0)=f00fe11e_c33c0ff7, M(1)=00ff00ff_00fff0ff, M(2)=0f0f0f0f_0f0fff00, M(3)=11113333_7777000f, M(4)=22224444_8888222f, M(5)=44448888_ffff4441, M(6)=8888ffff_11118882, M(7)=ffff1111_22221114. Bit 0 is the least significant bit of the data word and of the check byte.
- R2: The register port is written when `reg_we_i` is high at a rising clock edge. Address 0 loads the mask for data[63:32] from `reg_wdata_i`. Address 1 loads the mask for data[31:0]. Address 2 is the control word, with bits [7:0] as the check-byte mask and bit 8 as the enable. Writes to address 3 are ignored. A written value takes effect from the cycle after the edge. While injection is enabled, `wr_data_o` is `wr_data_i` XOR {high mask, low mask}, and `wr_chk_o` is the R1 check byte of `wr_data_i` XOR the check-byte mask. Both outputs are combinational.
- R3: While the enable is clear, loaded data masks have no effect: `wr_data_o` equals `wr_data_i` and `wr_chk_o` follows R1.
- R4: A control write with bit 8 clear disables injection and clears all three masks. Re-enabling afterwards with a zero check-byte mask leaves the write path unchanged until new data masks are loaded.
- R5: Read results appear on the outputs one clock edge after `rd_data_i`/`rd_chk_i` are sampled. When the syndrome (R1 check byte of `rd_data_i` XOR `rd_chk_i`) is zero, both error flags are 0, the index and check indicator are 0, and data and check byte pass through unchanged.
- R6: When the syndrome equals column k, where bit i of column k is bit k of M(i), data bit k is inverted on `rd_data_o`. In that case `rd_err_single_o`=1, `rd_err_idx_o`=k, `rd_err_in_chk_o`=0, and the check byte passes through. A data-column match takes precedence over R7.
- R7: When the syndrome has exactly one set bit j and matches no data column, `rd_err_single_o`=1, `rd_err_in_chk_o`=1 and `rd_err_idx_o`=j. `rd_chk_o` is `rd_chk_i` with bit j inverted, and the data passes through.
- R8: Any other nonzero syndrome sets `rd_err_multi_o`=1 and leaves `rd_err_single_o`=0, index 0 and check indicator 0. Data and check byte pass through uncorrected.
- R9: While `rst_ni` is low, all read-side outputs are 0 and injection is disabled with all masks cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write value |
| wr_data_i | input | 64 | Data word to be stored |
| wr_data_o | output | 64 | Data word toward memory, after injection |
| wr_chk_o | output | 8 | Check byte toward memory, after injection |
| rd_data_i | input | 64 | Data word read from memory |
| rd_chk_i | input | 8 | Check byte read from memory |
| rd_data_o | output | 64 | Corrected data word |
| rd_chk_o | output | 8 | Corrected check byte |
| rd_err_single_o | output | 1 | Single correctable error seen |
| rd_err_multi_o | output | 1 | Uncorrectable error seen |
| rd_err_idx_o | output | 6 | Index of the flipped bit |
| rd_err_in_chk_o | output | 1 | Flipped bit lies in the check byte |

## Verification
Write-path results are combinational and are due in the same cycle the data word is applied. Mask and enable changes count only from the cycle after the edge that captured the register write. Read-path results are due one rising edge after the word is presented. The bench drives every input on the falling edge and samples one time unit after the following rising edge, so each read is compared exactly one register stage later and each write-path result after its mask update has settled.

// File: rtl/ecc_secded_pkg.sv
package ecc_secded_pkg;
  localparam int DATA_W    = 64;
  localparam int CHK_W     = 8;
  localparam int HALF_W    = DATA_W / 2;
  localparam int IDX_W     = $clog2(DATA_W);
  localparam int CHK_IDX_W = $clog2(CHK_W);
  localparam int REG_AW    = 2;
  localparam int EN_BIT    = CHK_W;

  localparam logic [REG_AW-1:0] ADDR_HI   = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_LO   = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd2;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CHK_W-1:0]  chk_t;

  function automatic data_t chk_mask(input int i);
    case (i)
      0:       chk_mask = 64'hf00fe11e_c33c0ff7;
      1:       chk_mask = 64'h00ff00ff_00fff0ff;
      2:       chk_mask = 64'h0f0f0f0f_0f0fff00;
      3:       chk_mask = 64'h11113333_7777000f;
      4:       chk_mask = 64'h22224444_8888222f;
      5:       chk_mask = 64'h44448888_ffff4441;
      6:       chk_mask = 64'h8888ffff_11118882;
      7:       chk_mask = 64'hffff1111_22221114;
      default: chk_mask = '0;
    endcase
  endfunction

  function automatic chk_t calc_chk(input data_t d);
    calc_chk = '0;
    for (int i = 0; i < CHK_W; i++) calc_chk[i] = ^(d & chk_mask(i));
  endfunction

  // syndrome produced by a flip of data bit k
  function automatic chk_t col_of(input int k);
    data_t m;
    col_of = '0;
    for (int i = 0; i < CHK_W; i++) begin
      m = chk_mask(i);
      col_of[i] = m[k];
    end
  endfunction
endpackage

// File: rtl/ecc_secded_enc.sv
module ecc_secded_enc
  import ecc_secded_pkg::*;
(
  input  data_t data_i,
  output chk_t  chk_o
);
  for (genvar g = 0; g < CHK_W; g++) begin : g_bit
    assign chk_o[g] = ^(data_i & chk_mask(g));
  end
endmodule

// File: rtl/ecc_secded_inject.sv
module ecc_secded_inject
  import ecc_secded_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [HALF_W-1:0] reg_wdata_i,
  input  data_t             data_i,
  input  chk_t              chk_i,
  output data_t             data_o,
  output chk_t              chk_o,
  output logic              en_o
);
  logic [HALF_W-1:0] hi_q, lo_q;
  chk_t              cm_q;
  logic              en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
      cm_q <= '0;
      en_q <= 1'b0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        ADDR_HI: hi_q <= reg_wdata_i;
        ADDR_LO: lo_q <= reg_wdata_i;
        ADDR_CTRL: begin
          if (reg_wdata_i[EN_BIT]) begin
            cm_q <= reg_wdata_i[CHK_W-1:0];
            en_q <= 1'b1;
          end else begin
            // disable clears every mask
            hi_q <= '0;
            lo_q <= '0;
            cm_q <= '0;
            en_q <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign data_o = data_i ^ ({hi_q, lo_q} & {DATA_W{en_q}});
  assign chk_o  = chk_i ^ (cm_q & {CHK_W{en_q}});
  assign en_o   = en_q;
endmodule

// File: rtl/ecc_secded_dec.sv
module ecc_secded_dec
  import ecc_secded_pkg::*;
(
  input  data_t             data_i,
  input  chk_t              chk_i,
  output data_t             data_o,
  output chk_t              chk_o,
  output logic              single_o,
  output logic              multi_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              in_chk_o
);
  chk_t                 recalc, syn;
  logic [DATA_W-1:0]    hit;
  logic                 data_hit, chk_hit;
  logic [IDX_W-1:0]     data_idx;
  logic [CHK_IDX_W-1:0] chk_idx;

  ecc_secded_enc u_enc (.data_i(data_i), .chk_o(recalc));
  assign syn = recalc ^ chk_i;

  for (genvar g = 0; g < DATA_W; g++) begin : g_col
    assign hit[g] = (syn == col_of(g));
  end

  always_comb begin
    data_hit = |hit;
    data_idx = '0;
    for (int k = DATA_W - 1; k >= 0; k--) if (hit[k]) data_idx = IDX_W'(k);
    chk_idx = '0;
    for (int i = CHK_W - 1; i >= 0; i--) if (syn[i]) chk_idx = CHK_IDX_W'(i);
    chk_hit = !data_hit && $onehot(syn);

    data_o   = data_i;
    chk_o    = chk_i;
    single_o = 1'b0;
    multi_o  = 1'b0;
    idx_o    = '0;
    in_chk_o = 1'b0;
    if (data_hit) begin
      data_o[data_idx] = ~data_i[data_idx];
      single_o         = 1'b1;
      idx_o            = data_idx;
    end else if (chk_hit) begin
      chk_o[chk_idx] = ~chk_i[chk_idx];
      single_o       = 1'b1;
      idx_o          = IDX_W'(chk_idx);
      in_chk_o       = 1'b1;
    end else if (syn != '0) begin
      multi_o = 1'b1;
    end
  end
endmodule

// File: rtl/ecc_secded_codec.sv
module ecc_secded_codec
  import ecc_secded_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic [63:0]       wr_data_i,
  output logic [63:0]       wr_data_o,
  output logic [7:0]        wr_chk_o,
  input  logic [63:0]       rd_data_i,
  input  logic [7:0]        rd_chk_i,
  output logic [63:0]       rd_data_o,
  output logic [7:0]        rd_chk_o,
  output logic              rd_err_single_o,
  output logic              rd_err_multi_o,
  output logic [5:0]        rd_err_idx_o,
  output logic              rd_err_in_chk_o
);
  chk_t             wr_chk_raw;
  logic             inj_en;
  data_t            dec_data;
  chk_t             dec_chk;
  logic             dec_single, dec_multi, dec_in_chk;
  logic [IDX_W-1:0] dec_idx;

  ecc_secded_enc u_enc (.data_i(wr_data_i), .chk_o(wr_chk_raw));

  ecc_secded_inject u_inj (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .data_i      (wr_data_i),
    .chk_i       (wr_chk_raw),
    .data_o      (wr_data_o),
    .chk_o       (wr_chk_o),
    .en_o        (inj_en)
  );

  ecc_secded_dec u_dec (
    .data_i   (rd_data_i),
    .chk_i    (rd_chk_i),
    .data_o   (dec_data),
    .chk_o    (dec_chk),
    .single_o (dec_single),
    .multi_o  (dec_multi),
    .idx_o    (dec_idx),
    .in_chk_o (dec_in_chk)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o       <= '0;
      rd_chk_o        <= '0;
      rd_err_single_o <= 1'b0;
      rd_err_multi_o  <= 1'b0;
      rd_err_idx_o    <= '0;
      rd_err_in_chk_o <= 1'b0;
    end else begin
      rd_data_o       <= dec_data;
      rd_chk_o        <= dec_chk;
      rd_err_single_o <= dec_single;
      rd_err_multi_o  <= dec_multi;
      rd_err_idx_o    <= dec_idx;
      rd_err_in_chk_o <= dec_in_chk;
    end
  end
endmodule

// File: rtl/ecc_secded_chk.sv
module ecc_secded_chk
  import ecc_secded_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        inj_en_i,
  input logic        reg_we_i,
  input logic [1:0]  reg_addr_i,
  input logic        reg_en_bit_i,
  input logic [63:0] wr_data_i,
  input logic [63:0] wr_data_o,
  input logic [7:0]  wr_chk_o,
  input logic [63:0] rd_data_i,
  input logic [7:0]  rd_chk_i,
  input logic [63:0] rd_data_o,
  input logic [7:0]  rd_chk_o,
  input logic        rd_err_single_o,
  input logic        rd_err_multi_o,
  input logic [5:0]  rd_err_idx_o,
  input logic        rd_err_in_chk_o
);
  // R1 / R3: disabled write path is the plain encoding
  a_r3_pass_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inj_en_i |-> (wr_data_o == wr_data_i) && (wr_chk_o == calc_chk(wr_data_i)));

  // R4: a disabling control write turns injection off next cycle
  a_r4_off_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_CTRL && !reg_en_bit_i) |=> !inj_en_i);

  // R5: consistent word passes clean one cycle later
  a_r5_clean_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (calc_chk(rd_data_i) == rd_chk_i) |=>
      !rd_err_single_o && !rd_err_multi_o &&
      rd_data_o == $past(rd_data_i) && rd_chk_o == $past(rd_chk_i));

  // R6 / R7: a corrected result is self-consistent
  a_r6_fix_consistent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_single_o |-> calc_chk(rd_data_o) == rd_chk_o);

  a_r7_kind_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_in_chk_o |-> rd_err_single_o);

  // R8: uncorrectable result carries no location
  a_r8_multi_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_multi_o |-> !rd_err_single_o && rd_err_idx_o == '0 && !rd_err_in_chk_o);
endmodule

bind ecc_secded_codec ecc_secded_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .inj_en_i        (inj_en),
  .reg_we_i        (reg_we_i),
  .reg_addr_i      (reg_addr_i),
  .reg_en_bit_i    (reg_wdata_i[8]),
  .wr_data_i       (wr_data_i),
  .wr_data_o       (wr_data_o),
  .wr_chk_o        (wr_chk_o),
  .rd_data_i       (rd_data_i),
  .rd_chk_i        (rd_chk_i),
  .rd_data_o       (rd_data_o),
  .rd_chk_o        (rd_chk_o),
  .rd_err_single_o (rd_err_single_o),
  .rd_err_multi_o  (rd_err_multi_o),
  .rd_err_idx_o    (rd_err_idx_o),
  .rd_err_in_chk_o (rd_err_in_chk_o)
);

// File: tb/sim_ecc_secded_codec.sv
module sim_ecc_secded_codec;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [63:0] wr_data_i = '0;
  logic [63:0] wr_data_o;
  logic [7:0]  wr_chk_o;
  logic [63:0] rd_data_i = '0;
  logic [7:0]  rd_chk_i = '0;
  logic [63:0] rd_data_o;
  logic [7:0]  rd_chk_o;
  logic        rd_err_single_o, rd_err_multi_o, rd_err_in_chk_o;
  logic [5:0]  rd_err_idx_o;

  int n_checks = 0;
  int n_fail   = 0;

  // bench model of injection state
  logic [31:0] m_hi = '0, m_lo = '0;
  logic [7:0]  m_cm = '0;
  logic        m_en = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ecc_secded_codec u0 (.*);

  function automatic logic [63:0] tb_mask(input int i);
    logic [63:0] t [8];
    t[0] = 64'hf00fe11e_c33c0ff7; t[1] = 64'h00ff00ff_00fff0ff;
    t[2] = 64'h0f0f0f0f_0f0fff00; t[3] = 64'h11113333_7777000f;
    t[4] = 64'h22224444_8888222f; t[5] = 64'h44448888_ffff4441;
    t[6] = 64'h8888ffff_11118882; t[7] = 64'hffff1111_22221114;
    return t[i];
  endfunction

  function automatic logic [7:0] tb_enc(input logic [63:0] d);
    logic [7:0] c = '0;
    for (int i = 0; i < 8; i++) begin
      logic p = 1'b0;
      logic [63:0] m = tb_mask(i);
      for (int b = 0; b < 64; b++) if (m[b]) p = p ^ d[b];
      c[i] = p;
    end
    return c;
  endfunction

  function automatic logic [7:0] tb_col(input int k);
    logic [7:0] c;
    for (int i = 0; i < 8; i++) begin
      logic [63:0] m = tb_mask(i);
      c[i] = m[k];
    end
    return c;
  endfunction

  function automatic logic [63:0] gen_word(input int k);
    logic [31:0] a = 32'(k) * 32'h9e3779b9;
    logic [31:0] b = 32'(k) * 32'h7f4a7c15 + 32'h1;
    return {a, b};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [95:0] act, input logic [95:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] v);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = v;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0;
    case (a)
      2'd0: m_hi = v;
      2'd1: m_lo = v;
      2'd2: if (v[8]) begin m_cm = v[7:0]; m_en = 1'b1; end
            else begin m_hi = '0; m_lo = '0; m_cm = '0; m_en = 1'b0; end
      default: ;
    endcase
  endtask

  task automatic write_check(input logic [63:0] d, input string req,
                             output logic [63:0] od, output logic [7:0] oc);
    logic [63:0] ed;
    logic [7:0]  ec;
    @(negedge clk_i);
    wr_data_i = d;
    #1;
    ed = m_en ? d ^ {m_hi, m_lo} : d;
    ec = m_en ? tb_enc(d) ^ m_cm : tb_enc(d);
    check({wr_data_o, wr_chk_o} == {ed, ec}, req, "write path",
          {24'h0, wr_data_o, wr_chk_o}, {24'h0, ed, ec});
    od = wr_data_o; oc = wr_chk_o;
  endtask

  task automatic read_check(input logic [63:0] d, input logic [7:0] c);
    logic [7:0]  syn = tb_enc(d) ^ c;
    logic [63:0] ed = d;
    logic [7:0]  ec = c;
    logic        es = 1'b0, em = 1'b0, ek = 1'b0;
    logic [5:0]  ei = '0;
    int          hit = -1;
    string       req;
    for (int k = 63; k >= 0; k--) if (tb_col(k) == syn) hit = k;
    if (syn == 8'h0) req = "R5";
    else if (hit >= 0) begin
      req = "R6"; ed[hit] = ~d[hit]; es = 1'b1; ei = 6'(hit);
    end else if ($countones(syn) == 1) begin
      req = "R7"; es = 1'b1; ek = 1'b1;
      for (int j = 7; j >= 0; j--) if (syn[j]) ei = 6'(j);
      ec[ei[2:0]] = ~c[ei[2:0]];
    end else begin
      req = "R8"; em = 1'b1;
    end
    @(negedge clk_i);
    rd_data_i = d; rd_chk_i = c;
    @(posedge clk_i); #1;
    check({rd_data_o, rd_chk_o, rd_err_single_o, rd_err_multi_o, rd_err_in_chk_o, rd_err_idx_o}
          == {ed, ec, es, em, ek, ei}, req, "read decode",
          {15'h0, rd_data_o, rd_chk_o, rd_err_single_o, rd_err_multi_o, rd_err_in_chk_o, rd_err_idx_o},
          {15'h0, ed, ec, es, em, ek, ei});
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] bases [4];
    logic [63:0] od;
    logic [7:0]  oc;
    bases[0] = 64'h0; bases[1] = '1;
    bases[2] = 64'h01234567_89abcdef; bases[3] = 64'hdeadbeef_cafef00d;

    // R9: reset state
    rd_data_i = 64'hffff_0000_ffff_0000; rd_chk_i = 8'h5a;
    wr_data_i = bases[2];
    #(3*CLK_PERIOD);
    check({rd_data_o, rd_chk_o, rd_err_single_o, rd_err_multi_o, rd_err_in_chk_o, rd_err_idx_o} == '0,
          "R9", "read outputs in reset",
          {15'h0, rd_data_o, rd_chk_o, rd_err_single_o, rd_err_multi_o, rd_err_in_chk_o, rd_err_idx_o}, '0);
    check(wr_data_o == wr_data_i, "R9", "injection off in reset",
          {32'h0, wr_data_o}, {32'h0, wr_data_i});
    @(negedge clk_i); rst_ni = 1'b1;

    // R1: encoding
    for (int k = 0; k < 4; k++) write_check(bases[k], "R1", od, oc);
    for (int k = 0; k < 32; k++) write_check(gen_word(k), "R1", od, oc);

    // R5: clean reads
    for (int k = 0; k < 4; k++) read_check(bases[k], tb_enc(bases[k]));
    for (int k = 0; k < 32; k++) read_check(gen_word(k), tb_enc(gen_word(k)));

    // R6: every data bit flipped
    for (int b = 0; b < 4; b++)
      for (int k = 0; k < 64; k++)
        read_check(bases[b] ^ (64'h1 << k), tb_enc(bases[b]));

    // R7: every check bit flipped
    for (int b = 0; b < 4; b++)
      for (int j = 0; j < 8; j++)
        read_check(bases[b], tb_enc(bases[b]) ^ (8'h1 << j));

    // R8: all data-bit pairs, plus data+check and check pairs
    for (int i = 0; i < 64; i++)
      for (int j = i + 1; j < 64; j++)
        read_check(bases[2] ^ (64'h1 << i) ^ (64'h1 << j), tb_enc(bases[2]));
    for (int i = 0; i < 64; i++)
      read_check(bases[3] ^ (64'h1 << i), tb_enc(bases[3]) ^ 8'h01);
    for (int i = 0; i < 8; i++)
      for (int j = i + 1; j < 8; j++)
        read_check(bases[1], tb_enc(bases[1]) ^ (8'h1 << i) ^ (8'h1 << j));

    // R3: masks loaded while disabled have no effect
    reg_write(2'd0, 32'h0000_0010);
    reg_write(2'd1, 32'h0000_0001);
    for (int k = 0; k < 4; k++) write_check(bases[k], "R3", od, oc);

    // R2: enable, data masks give a double error on readback
    reg_write(2'd2, 32'h0000_0100);
    write_check(bases[2], "R2", od, oc);
    read_check(od, oc);
    // R2: single low-word flip, corrected on readback
    reg_write(2'd0, 32'h0);
    reg_write(2'd1, 32'h8000_0000);
    write_check(bases[3], "R2", od, oc);
    read_check(od, oc);
    // R2: high-word flip
    reg_write(2'd1, 32'h0);
    reg_write(2'd0, 32'h0004_0000);
    write_check(bases[1], "R2", od, oc);
    read_check(od, oc);
    // R2: check-byte flip only
    reg_write(2'd0, 32'h0);
    reg_write(2'd2, 32'h0000_0120);
    write_check(bases[2], "R2", od, oc);
    read_check(od, oc);
    // R2: address 3 ignored
    reg_write(2'd3, 32'hffff_ffff);
    write_check(bases[0], "R2", od, oc);

    // R4: disable clears all masks
    reg_write(2'd0, 32'hff00_ff00);
    reg_write(2'd1, 32'h00ff_00ff);
    reg_write(2'd2, 32'h0000_0000);
    write_check(bases[2], "R4", od, oc);
    reg_write(2'd2, 32'h0000_0100);
    write_check(bases[3], "R4", od, oc);
    check(od == bases[3] && oc == tb_enc(bases[3]), "R4", "masks cleared after disable",
          {24'h0, od, oc}, {24'h0, bases[3], tb_enc(bases[3])});

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule